// File: doc/BRIEF.md
# Frame-driven register access engine

This block accepts command frames made of 32-bit words, each word tagged with start-of-frame and end-of-frame markers, and stores them in an internal command FIFO. It turns each well-formed three-word frame into one cycle on a simple register bus. The first word is a header whose bit 0 selects read or write, the second is the address and the third is the write data. The bus cycle holds chip select until the acknowledge that matches its direction arrives.

For a read, the returned word is packed into a three-word response frame: a type code, the address and the data. That frame goes to a receive memory controller over a request/acknowledge handshake. The block also watches an interrupt line for rising edges. Each detected edge leads to one interrupt frame in the same three-word format, with a zero address and a running edge count as its data.

The command input is a valid/ready stream. A word is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low exactly when the FIFO is full, and a word offered while it is low is not stored, so the sender must hold it and offer it again. The response side has no back-pressure once a frame starts: after the acknowledge pulse, the three words follow on back-to-back cycles.

Top module: `frame_reg_engine`

## Requirements
- R1: A synchronous active-high reset empties the command FIFO, clears the pending read result and the pending interrupt, and zeroes the interrupt edge count. After reset `cmd_ready`=1 and `bus_sel`, `rsp_req` and `rsp_valid` are 0, and no frame pending before reset is ever sent.
- R2: The FIFO holds `FIFO_DEPTH` words. `cmd_ready` falls once that many words are stored. A word offered while `cmd_ready` is low is dropped and never reaches the bus.
- R3: A command frame is exactly three words. Word 1 carries sof=1 and eof=0, and its bit 0 selects the direction (1 = read, 0 = write). Word 2 carries the address. Word 3 carries eof=1 and the write data.
- R4: During a command cycle `bus_sel`=1 and `bus_addr` and `bus_read` stay stable. The cycle ends only on `bus_rd_ack` for a read or `bus_wr_ack` for a write; the acknowledge for the other direction is ignored. `bus_sel` is low in the cycle after the ending acknowledge.
- R5: A write drives word 3 on `bus_wdata` and produces no response frame.
- R6: A read captures `bus_rdata` in the cycle of `bus_rd_ack`. It then sends a response frame with type 0x2000, the command address and the captured data.
- R7: `rsp_req` stays high until the single-cycle `rsp_ack`. The three words follow on the three cycles right after the acknowledge: sof on the first, eof on the third, and `rsp_valid` high on those cycles only.
- R8: A rising edge on `irq_in` sends a frame with type 0x2001, address 0, and data equal to the number of rising edges seen since reset. A held level does not retrigger.
- R9: If a read result and an interrupt are pending together, the read frame goes first. Further edges while an interrupt is pending merge into it, and that one frame reports the count at the moment its request rises.
- R10: Malformed frames are discarded without a bus cycle. This covers a word without sof outside a frame, a frame ending before word 3, and a frame whose word 3 lacks eof (which is skipped through its eof). A sof mid-frame starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | FIFO can take a word (low when full) |
| cmd_sof | input | 1 | First word of a command frame |
| cmd_eof | input | 1 | Last word of a command frame |
| cmd_data | input | 32 | Command word |
| bus_sel | output | 1 | Register bus chip select, active high |
| bus_read | output | 1 | Direction, 1 = read, 0 = write |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rd_ack | input | 1 | Ends a read cycle; read data valid |
| bus_wr_ack | input | 1 | Ends a write cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_rd_ack` |
| irq_in | input | 1 | Interrupt line, rising-edge detected |
| rsp_req | output | 1 | Response frame request, held until ack |
| rsp_ack | input | 1 | Single-cycle grant from the receiver |
| rsp_valid | output | 1 | Response word valid |
| rsp_sof | output | 1 | First response word |
| rsp_eof | output | 1 | Last response word |
| rsp_data | output | 32 | Response word |

## Verification
A command word pushed on one edge leaves the FIFO on the next edge when the engine is collecting. Chip select therefore rises in the cycle after the edge that takes word 3, and it falls in the cycle after the edge that samples the matching acknowledge. `rsp_req` rises two edges after the read acknowledge, or one edge after an interrupt edge is registered, when the packer is idle. Once `rsp_ack` is sampled, the words sit on the first, second and third following cycles, and `rsp_valid` is low on the fourth. The bench waits for chip select and request as events. From the acknowledge on it samples each result at its exact cycle at the falling clock edge.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] TYPE_READ = 32'h0000_2000;
  localparam logic [WORD_W-1:0] TYPE_IRQ  = 32'h0000_2001;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [WORD_W-1:0] data;
  } cmd_word_t;

  typedef enum logic [2:0] {
    EX_HDR, EX_ADDR, EX_DATA, EX_SKIP, EX_BUS, EX_RWAIT
  } ex_state_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_REQ, TX_W1, TX_W2, TX_W3
  } tx_state_t;
endpackage

// File: rtl/fre_cmd_fifo.sv
module fre_cmd_fifo
  import fre_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  output logic      in_ready,
  input  cmd_word_t in_word,
  output logic      out_valid,
  output cmd_word_t out_word,
  input  logic      out_pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cmd_word_t       store [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   fill;
  logic            do_push, do_pop;

  assign in_ready  = (fill != CW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_word  = store[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_pop && out_valid;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !out_pop) |=> !in_ready); // R2
endmodule

// File: rtl/fre_cmd_exec.sv
module fre_cmd_exec
  import fre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  cmd_word_t         head,
  output logic              head_pop,
  output logic              bus_sel,
  output logic              bus_read,
  output logic [WORD_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd_ack,
  input  logic              bus_wr_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              slot_full,
  output logic              rd_push,
  output logic [WORD_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  ex_state_t         state;
  logic              is_read;
  logic [WORD_W-1:0] addr_q, wdata_q;
  logic              collecting, new_hdr, done_ack;

  assign collecting = (state == EX_HDR) || (state == EX_ADDR) ||
                      (state == EX_DATA) || (state == EX_SKIP);
  assign head_pop   = collecting && head_valid;
  assign new_hdr    = head.sof && !head.eof;
  assign done_ack   = is_read ? bus_rd_ack : bus_wr_ack;

  assign bus_sel   = (state == EX_BUS);
  assign bus_read  = is_read;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rd_push   = bus_sel && is_read && bus_rd_ack;
  assign rd_addr   = addr_q;
  assign rd_data   = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= EX_HDR;
      is_read <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        EX_HDR, EX_ADDR, EX_DATA, EX_SKIP: begin
          if (head_pop) begin
            if (head.sof) begin
              // any start marker opens a frame afresh
              if (new_hdr) begin
                is_read <= head.data[0];
                state   <= EX_ADDR;
              end else begin
                state <= EX_HDR;
              end
            end else begin
              case (state)
                EX_ADDR: begin
                  if (head.eof) state <= EX_HDR;
                  else begin
                    addr_q <= head.data;
                    state  <= EX_DATA;
                  end
                end
                EX_DATA: begin
                  if (head.eof) begin
                    wdata_q <= head.data;
                    state   <= EX_BUS;
                  end else begin
                    state <= EX_SKIP;
                  end
                end
                EX_SKIP: if (head.eof) state <= EX_HDR;
                default: state <= EX_HDR;
              endcase
            end
          end
        end
        EX_BUS: begin
          if (done_ack) state <= is_read ? EX_RWAIT : EX_HDR;
        end
        EX_RWAIT: begin
          if (!slot_full) state <= EX_HDR;
        end
        default: state <= EX_HDR;
      endcase
    end
  end

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !(bus_read ? bus_rd_ack : bus_wr_ack)) |=>
      (bus_sel && $stable(bus_addr) && $stable(bus_read))); // R4
  AST_SEL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && (bus_read ? bus_rd_ack : bus_wr_ack)) |=> !bus_sel); // R4
  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    rd_push |-> !slot_full); // R6
endmodule

// File: rtl/fre_rsp_tx.sv
module fre_rsp_tx
  import fre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_push,
  input  logic [WORD_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              slot_full,
  input  logic              irq_in,
  output logic              rsp_req,
  input  logic              rsp_ack,
  output logic              rsp_valid,
  output logic              rsp_sof,
  output logic              rsp_eof,
  output logic [WORD_W-1:0] rsp_data
);
  tx_state_t         state;
  logic              slot_v, irq_q, irq_pend, irq_edge;
  logic              take_rd, take_irq;
  logic [WORD_W-1:0] slot_addr, slot_data, irq_cnt;
  logic [WORD_W-1:0] f_type, f_addr, f_data;

  assign irq_edge  = irq_in && !irq_q;
  assign slot_full = slot_v;
  assign take_rd   = (state == TX_IDLE) && slot_v;
  assign take_irq  = (state == TX_IDLE) && !slot_v && irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v    <= 1'b0;
      slot_addr <= '0;
      slot_data <= '0;
      irq_q     <= 1'b0;
      irq_pend  <= 1'b0;
      irq_cnt   <= '0;
    end else begin
      irq_q <= irq_in;
      if (rd_push) begin
        slot_v    <= 1'b1;
        slot_addr <= rd_addr;
        slot_data <= rd_data;
      end else if (take_rd) begin
        slot_v <= 1'b0;
      end
      if (irq_edge) begin
        irq_pend <= 1'b1;
        irq_cnt  <= irq_cnt + 1'b1;
      end else if (take_irq) begin
        irq_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      f_type <= '0;
      f_addr <= '0;
      f_data <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (take_rd) begin
            f_type <= TYPE_READ;
            f_addr <= slot_addr;
            f_data <= slot_data;
            state  <= TX_REQ;
          end else if (take_irq) begin
            f_type <= TYPE_IRQ;
            f_addr <= '0;
            f_data <= irq_cnt;
            state  <= TX_REQ;
          end
        end
        TX_REQ:  if (rsp_ack) state <= TX_W1;
        TX_W1:   state <= TX_W2;
        TX_W2:   state <= TX_W3;
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_req   = (state == TX_REQ);
    rsp_valid = (state == TX_W1) || (state == TX_W2) || (state == TX_W3);
    rsp_sof   = (state == TX_W1);
    rsp_eof   = (state == TX_W3);
    case (state)
      TX_W1:   rsp_data = f_type;
      TX_W2:   rsp_data = f_addr;
      TX_W3:   rsp_data = f_data;
      default: rsp_data = '0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_req && !rsp_ack) |=> rsp_req); // R7
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    (rsp_req && rsp_ack) |=> (rsp_valid && rsp_sof && !rsp_req)); // R7
  AST_LAST_WORD: assert property (@(posedge clk) disable iff (rst)
    rsp_eof |-> ($past(rsp_valid) && $past(rsp_valid, 2) && !$past(rsp_eof))); // R7
  AST_TYPE_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_sof |-> ((rsp_data == TYPE_READ) || (rsp_data == TYPE_IRQ))); // R8
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!rsp_req && !rsp_valid && slot_v && irq_pend) |=> (rsp_req && slot_v == 1'b0)); // R9
endmodule

// File: rtl/frame_reg_engine.sv
module frame_reg_engine
  import fre_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_sof,
  input  logic        cmd_eof,
  input  logic [31:0] cmd_data,
  output logic        bus_sel,
  output logic        bus_read,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_rd_ack,
  input  logic        bus_wr_ack,
  input  logic [31:0] bus_rdata,
  input  logic        irq_in,
  output logic        rsp_req,
  input  logic        rsp_ack,
  output logic        rsp_valid,
  output logic        rsp_sof,
  output logic        rsp_eof,
  output logic [31:0] rsp_data
);
  cmd_word_t         in_word, head;
  logic              head_valid, head_pop;
  logic              slot_full, rd_push;
  logic [WORD_W-1:0] rd_addr, rd_data;

  assign in_word = '{sof: cmd_sof, eof: cmd_eof, data: cmd_data};

  fre_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_word(in_word),
    .out_valid(head_valid), .out_word(head), .out_pop(head_pop)
  );

  fre_cmd_exec u_exec (
    .clk(clk), .rst(rst),
    .head_valid(head_valid), .head(head), .head_pop(head_pop),
    .bus_sel(bus_sel), .bus_read(bus_read), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_ack(bus_rd_ack), .bus_wr_ack(bus_wr_ack),
    .bus_rdata(bus_rdata), .slot_full(slot_full), .rd_push(rd_push),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fre_rsp_tx u_tx (
    .clk(clk), .rst(rst),
    .rd_push(rd_push), .rd_addr(rd_addr), .rd_data(rd_data),
    .slot_full(slot_full), .irq_in(irq_in),
    .rsp_req(rsp_req), .rsp_ack(rsp_ack), .rsp_valid(rsp_valid),
    .rsp_sof(rsp_sof), .rsp_eof(rsp_eof), .rsp_data(rsp_data)
  );

  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && !bus_sel && !head_pop) |=> !cmd_ready); // R2
  AST_VALID_ONLY_FRAME: assert property (@(posedge clk) disable iff (rst)
    rsp_req |-> !rsp_valid); // R7
endmodule

// File: tb/tb_frame_reg_engine.sv
module tb_frame_reg_engine;
  localparam int DEPTH = 8;
  localparam logic [31:0] T_RD  = 32'h2000;
  localparam logic [31:0] T_IRQ = 32'h2001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_sof = 0, cmd_eof = 0;
  logic [31:0] cmd_data = '0;
  logic cmd_ready, bus_sel, bus_read;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_rd_ack = 0, bus_wr_ack = 0;
  logic [31:0] bus_rdata = '0;
  logic irq_in = 0, rsp_ack = 0;
  logic rsp_req, rsp_valid, rsp_sof, rsp_eof;
  logic [31:0] rsp_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  frame_reg_engine #(.FIFO_DEPTH(DEPTH)) dut (.*);

  typedef struct packed {
    logic        rd;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0000_0010, 32'hDEAD_BEEF, 32'h0, 4'd1},
    '{1'b1, 32'h0000_0010, 32'h0,         32'h1234_5678, 4'd2},
    '{1'b1, 32'hFFFF_FFFC, 32'h5555_0000, 32'hA5A5_5A5A, 4'd1},
    '{1'b0, 32'h8000_0000, 32'h0000_0001, 32'h0, 4'd4},
    '{1'b1, 32'h0000_0000, 32'h0,         32'hFFFF_FFFF, 4'd3},
    '{1'b0, 32'h0000_0ABC, 32'hFFFF_FFFF, 32'h0, 4'd1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic sof, logic eof, logic [31:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_sof = sof; cmd_eof = eof; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0; cmd_sof = 0; cmd_eof = 0;
  endtask

  task automatic send_cmd(logic rd, logic [31:0] a, logic [31:0] wd);
    push(1, 0, {31'h0, rd});
    push(0, 0, a);
    push(0, 1, wd);
  endtask

  task automatic bus_serve(logic rd, logic [31:0] a, logic [31:0] wd,
                           logic [31:0] rdat, int lat);
    @(negedge clk);
    while (!bus_sel) @(negedge clk);
    chk("R3 address", bus_addr, a);
    chk("R3 direction", {31'h0, bus_read}, {31'h0, rd});
    if (!rd) chk("R5 write data", bus_wdata, wd);
    for (int i = 0; i < lat; i++) begin
      if (i == 0) begin
        if (rd) bus_wr_ack = 1; else bus_rd_ack = 1;
      end
      @(negedge clk);
      bus_wr_ack = 0; bus_rd_ack = 0;
    end
    chk("R4 select held", {31'h0, bus_sel}, 32'h1);
    chk("R4 address stable", bus_addr, a);
    if (rd) begin bus_rd_ack = 1; bus_rdata = rdat; end
    else bus_wr_ack = 1;
    @(negedge clk);
    bus_rd_ack = 0; bus_wr_ack = 0; bus_rdata = 32'hBAD0_BAD0;
    chk("R4 select drops", {31'h0, bus_sel}, 32'h0);
  endtask

  task automatic rsp_serve(logic [31:0] ty, logic [31:0] a, logic [31:0] d,
                           string tag);
    @(negedge clk);
    while (!rsp_req) @(negedge clk);
    chk("R7 idle valid", {31'h0, rsp_valid}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 req held", {31'h0, rsp_req}, 32'h1);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    chk("R7 word1 flags", {29'h0, rsp_valid, rsp_sof, rsp_eof}, 32'h6);
    chk({tag, " type"}, rsp_data, ty);
    @(negedge clk);
    chk("R7 word2 flags", {29'h0, rsp_valid, rsp_sof, rsp_eof}, 32'h4);
    chk({tag, " address"}, rsp_data, a);
    @(negedge clk);
    chk("R7 word3 flags", {29'h0, rsp_valid, rsp_sof, rsp_eof}, 32'h5);
    chk({tag, " data"}, rsp_data, d);
    @(negedge clk);
    chk("R7 valid after frame", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic quiet(int n, string tag);
    repeat (n) @(negedge clk);
    chk(tag, {31'h0, rsp_req}, 32'h0);
  endtask

  task automatic irq_edge();
    @(negedge clk); irq_in = 1;
    repeat (2) @(negedge clk); irq_in = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs", {28'h0, cmd_ready, bus_sel, rsp_req, rsp_valid}, 32'h8);

    // table of command vectors
    foreach (VECS[k]) begin
      send_cmd(VECS[k].rd, VECS[k].addr, VECS[k].wdata);
      bus_serve(VECS[k].rd, VECS[k].addr, VECS[k].wdata, VECS[k].rdata, int'(VECS[k].lat));
      if (VECS[k].rd) rsp_serve(T_RD, VECS[k].addr, VECS[k].rdata, "R6 read frame");
      else quiet(8, "R5 no frame after write");
    end

    // R10 malformed frames
    push(0, 1, 32'h1);                       // stray word
    push(1, 0, 32'h0); push(0, 1, 32'h11);   // ends early
    push(1, 0, 32'h0); push(0, 0, 32'h22); push(0, 0, 32'h33);
    push(0, 0, 32'h44); push(0, 1, 32'h55);  // too long
    push(1, 0, 32'h0); push(1, 0, 32'h0);    // restart on sof
    push(0, 0, 32'h77); push(0, 1, 32'h99);
    bus_serve(0, 32'h77, 32'h99, 0, 1);
    quiet(4, "R10 no extra cycle");
    chk("R10 no extra select", {31'h0, bus_sel}, 32'h0);

    // R2 fill while the bus is stalled
    send_cmd(0, 32'hA0, 32'h1);
    @(negedge clk); while (!bus_sel) @(negedge clk);
    send_cmd(0, 32'hB0, 32'h2);
    send_cmd(0, 32'hC0, 32'h3);
    push(1, 0, 32'h0); push(0, 0, 32'hD0);
    chk("R2 full after depth words", {31'h0, cmd_ready}, 32'h0);
    cmd_valid = 1; cmd_eof = 1; cmd_data = 32'hBADB_AD00;
    @(negedge clk);
    cmd_valid = 0; cmd_eof = 0;
    bus_serve(0, 32'hA0, 32'h1, 0, 1);
    push(0, 1, 32'h4444);
    bus_serve(0, 32'hB0, 32'h2, 0, 1);
    bus_serve(0, 32'hC0, 32'h3, 0, 1);
    bus_serve(0, 32'hD0, 32'h4444, 0, 1);  // R2: refused word not stored

    // R8 interrupt edge, level held
    @(negedge clk); irq_in = 1;
    rsp_serve(T_IRQ, 32'h0, 32'd1, "R8 irq frame");
    quiet(10, "R8 level no retrigger");
    irq_in = 0;

    // R9 priority and merge
    irq_edge();                               // count 2, req raised
    send_cmd(1, 32'h5C, 32'h0);
    bus_serve(1, 32'h5C, 32'h0, 32'hC0DE_0001, 1);
    irq_edge(); irq_edge();                   // counts 3, 4 merged
    rsp_serve(T_IRQ, 32'h0, 32'd2, "R9 first irq");
    rsp_serve(T_RD, 32'h5C, 32'hC0DE_0001, "R9 read first");
    rsp_serve(T_IRQ, 32'h0, 32'd4, "R9 merged irq");
    quiet(10, "R9 single merged frame");

    // R1 reset drops a pending frame
    irq_edge();
    @(negedge clk); while (!rsp_req) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 req cleared", {31'h0, rsp_req}, 32'h0);
    quiet(10, "R1 pending irq dropped");
    irq_edge();
    rsp_serve(T_IRQ, 32'h0, 32'd1, "R1 count cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule